// File: doc/BRIEF.md
# Counter Clock Routing and Interrupt Steering

This block is the glue between a host I/O bus, a bank of three 16-bit counters, two parallel port devices and three shared, active-high interrupt lines. It claims a 16-byte window of I/O space and splits that window into three regions. Two regions are chip selects for the parallel port devices. The third is a chip select for the counter device. The last four bytes of the window hold two local configuration registers, and each of those registers answers at two adjacent offsets.

The counter source register picks where each counter's count events come from: its own input pin, a free-running oscillator tick, or, for counters 1 and 2, the output of the previous counter. Two or three counters can therefore be chained. Count events leave the block as one-cycle count-enable pulses on the system clock, never as derived clocks.

The interrupt register picks, for each line, one of two pending sources and gates it with an enable. Each line's output is the enable of a tristate driver whose data input is tied high. When the driver is off, an external pull-down gives logic 0, so several boards can share the same line.

Top module: `cir_top`

## Requirements
- R1: A bus access (read or write) whose address bits 9..4 equal bits 9..4 of BASE_ADDR (default 0x300) is decoded by offset bits 3..2. Offsets 0-3 raise cs_ppi[0], offsets 4-7 raise cs_ppi[1] and offsets 8-11 raise cs_ctr, combinationally. An address outside the window raises no select.
- R2: A write at offset 12 or 13 loads the counter source register from bus_wdata[4:0]. A read at offset 12 or 13 returns that register in bus_rdata[4:0] with bits 7:5 zero. The register resets to zero.
- R3: A write at offset 14 or 15 loads the interrupt register from bus_wdata[5:0]: bits 5:3 are source selects for lines 2..0 and bits 2:0 are enables for lines 2..0. A read at offset 14 or 15 returns it with bits 7:6 zero. The register resets to zero.
- R4: Writes outside the window, or to offsets 0-11, leave both registers unchanged. bus_rdata is zero unless a read hits offsets 12-15.
- R5: Counter 0 uses source register bit 0. With 0, cnt_en[0] gives one pulse for each rising edge of ext_in[0], after SYNC_STAGES synchronizer flops. With 1, cnt_en[0] repeats osc_tick one cycle later.
- R6: Counter 1 uses source register bits 2:1. 00 selects rising edges of ext_in[1], 01 selects osc_tick, and 1x selects rising edges of ctr_out[0], so counter 1 is chained to counter 0.
- R7: Counter 2 uses source register bits 4:3 with the same coding as counter 1. Its 1x code selects rising edges of ctr_out[1].
- R8: When interrupt enable bit n is 1, irq_oe[n] follows the selected pending source. Source bit 3+n = 1 selects the level of ctr_out[n], registered once. Source bit 3+n = 0 selects the synchronized level of ppi_c0[0] for line 0, ppi_c0[1] for line 1, or ext_irq for line 2.
- R9: When interrupt enable bit n is 0, irq_oe[n] stays low whatever its source does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 10 | Host I/O address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of local registers, zero otherwise |
| cs_ppi | output | 2 | Selects for the two parallel port devices |
| cs_ctr | output | 1 | Select for the counter device |
| ext_in | input | 3 | Asynchronous counter input pins |
| osc_tick | input | 1 | Synchronous oscillator tick, one cycle per period |
| ctr_out | input | 3 | Counter outputs, synchronous to clk |
| cnt_en | output | 3 | Count-enable pulses for counters 0..2 |
| ppi_c0 | input | 2 | Port C bit 0 of each parallel port device |
| ext_irq | input | 1 | External interrupt pin |
| irq_oe | output | 3 | Tristate drive enables for the three interrupt lines |

## Verification
The assertions take for granted that ctr_out and osc_tick are synchronous to clk, that osc_tick is a pulse and not a level, and that the three kinds of bus region are never accessed in the same cycle. The stimulus keeps to this: it changes every input half a cycle away from the active edge, drives osc_tick high for a single cycle at a time, and keeps each pin level for at least three cycles so that every edge crosses the synchronizer. Source configurations are loaded only while all count sources are idle, so each pulse count belongs to a single routing choice.

// File: rtl/cir_pkg.sv
package cir_pkg;
   localparam int NUM_CTR  = 3;
   localparam int WIN_W    = 4;
   localparam int INSEL_W  = 5;
   localparam int IRQCFG_W = 6;

   typedef enum logic [1:0] {
      RG_PPI0  = 2'd0,
      RG_PPI1  = 2'd1,
      RG_CTR   = 2'd2,
      RG_LOCAL = 2'd3
   } region_e;

   typedef enum logic [1:0] {
      SRC_PIN  = 2'b00,
      SRC_OSC  = 2'b01,
      SRC_CHN0 = 2'b10,
      SRC_CHN1 = 2'b11
   } csrc_e;
endpackage

// File: rtl/cir_sync.sv
module cir_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/cir_decode.sv
module cir_decode
   import cir_pkg::*;
#(
   parameter int                ADDR_W    = 10,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 10'h300
) (
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   output logic [1:0]        cs_ppi,
   output logic              cs_ctr,
   output logic              wr_insel,
   output logic              wr_irq,
   output logic              rd_insel,
   output logic              rd_irq
);
   localparam int TAG_W = ADDR_W - WIN_W;

   logic [TAG_W-1:0] tag;
   logic [WIN_W-1:0] off;
   logic             hit;
   logic             acc;
   region_e          rg;
   logic             loc;

   assign tag = bus_addr[ADDR_W-1:WIN_W];
   assign off = bus_addr[WIN_W-1:0];
   assign hit = (tag == BASE_ADDR[ADDR_W-1:WIN_W]);
   assign acc = hit & (bus_rd | bus_wr);
   assign rg  = region_e'(off[3:2]);
   assign loc = hit & (rg == RG_LOCAL);

   always_comb begin
      cs_ppi[0] = acc & (rg == RG_PPI0);
      cs_ppi[1] = acc & (rg == RG_PPI1);
      cs_ctr    = acc & (rg == RG_CTR);
   end

   // offset bit 0 is ignored, so each register answers at two offsets
   assign wr_insel = loc & bus_wr & ~off[1];
   assign wr_irq   = loc & bus_wr &  off[1];
   assign rd_insel = loc & bus_rd & ~off[1];
   assign rd_irq   = loc & bus_rd &  off[1];
endmodule

// File: rtl/cir_regs.sv
module cir_regs
   import cir_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_insel,
   input  logic                wr_irq,
   input  logic                rd_insel,
   input  logic                rd_irq,
   input  logic [DATA_W-1:0]   wdata,
   output logic [INSEL_W-1:0]  insel,
   output logic [IRQCFG_W-1:0] irqcfg,
   output logic [DATA_W-1:0]   rdata
);
   logic [DATA_W-1:0] unused_wdata;
   assign unused_wdata = wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         insel  <= '0;
         irqcfg <= '0;
      end else begin
         if (wr_insel) insel  <= wdata[INSEL_W-1:0];
         if (wr_irq)   irqcfg <= wdata[IRQCFG_W-1:0];
      end
   end

   always_comb begin
      rdata = '0;
      if (rd_insel)    rdata[INSEL_W-1:0]  = insel;
      else if (rd_irq) rdata[IRQCFG_W-1:0] = irqcfg;
   end

   a_r2_insel_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_insel |=> $stable(insel));
   a_r3_irqcfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_irq |=> $stable(irqcfg));
endmodule

// File: rtl/cir_clk_route.sv
module cir_clk_route
   import cir_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [INSEL_W-1:0] insel,
   input  logic [NUM_CTR-1:0] ext_in,
   input  logic               osc_tick,
   input  logic [NUM_CTR-1:0] ctr_out,
   output logic [NUM_CTR-1:0] cnt_en
);
   logic [NUM_CTR-1:0] pin_s, pin_p, pin_rise;
   logic [NUM_CTR-2:0] co_p, co_rise;
   logic               unused_co_top;
   logic [NUM_CTR-1:0] pick;

   assign unused_co_top = ctr_out[NUM_CTR-1];

   cir_sync #(.W(NUM_CTR), .STAGES(SYNC_STAGES)) u_pin_sync (
      .clk(clk), .rst_n(rst_n), .d(ext_in), .q(pin_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_p <= '0;
         co_p  <= '0;
      end else begin
         pin_p <= pin_s;
         co_p  <= ctr_out[NUM_CTR-2:0];
      end
   end

   assign pin_rise = pin_s & ~pin_p;
   assign co_rise  = ctr_out[NUM_CTR-2:0] & ~co_p;

   for (genvar g = 0; g < NUM_CTR; g++) begin : g_ch
      if (g == 0) begin : g_first
         assign pick[g] = insel[0] ? osc_tick : pin_rise[g];
         a_r5_en_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_en[g] |-> $past(pin_rise[g] | osc_tick));
      end else begin : g_chain
         csrc_e sel;
         assign sel = csrc_e'(insel[2*g -: 2]);
         always_comb begin
            case (sel)
               SRC_PIN: pick[g] = pin_rise[g];
               SRC_OSC: pick[g] = osc_tick;
               default: pick[g] = co_rise[g-1];
            endcase
         end
         a_r6_en_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_en[g] |-> $past(pin_rise[g] | osc_tick | co_rise[g-1]));
         a_r7_chain_follows: assert property (@(posedge clk) disable iff (!rst_n)
            (sel[1] && co_rise[g-1]) |=> cnt_en[g]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_en <= '0;
      else        cnt_en <= pick;
   end
endmodule

// File: rtl/cir_irq_steer.sv
module cir_irq_steer
   import cir_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [IRQCFG_W-1:0] irqcfg,
   input  logic [1:0]          ppi_c0,
   input  logic                ext_irq,
   input  logic [NUM_CTR-1:0]  ctr_out,
   output logic [NUM_CTR-1:0]  irq_oe
);
   logic [NUM_CTR-1:0] pin_s;
   logic [NUM_CTR-1:0] pend;

   cir_sync #(.W(NUM_CTR), .STAGES(SYNC_STAGES)) u_irq_sync (
      .clk(clk), .rst_n(rst_n), .d({ext_irq, ppi_c0}), .q(pin_s));

   for (genvar g = 0; g < NUM_CTR; g++) begin : g_line
      assign pend[g] = irqcfg[NUM_CTR+g] ? ctr_out[g] : pin_s[g];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_oe[g] <= 1'b0;
         else        irq_oe[g] <= irqcfg[g] & pend[g];
      end

      a_r9_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
         !irqcfg[g] |=> !irq_oe[g]);
      a_r8_counter_source: assert property (@(posedge clk) disable iff (!rst_n)
         (irqcfg[g] && irqcfg[NUM_CTR+g]) |=> (irq_oe[g] == $past(ctr_out[g])));
   end
endmodule

// File: rtl/cir_top.sv
module cir_top
   import cir_pkg::*;
#(
   parameter int                ADDR_W      = 10,
   parameter int                DATA_W      = 8,
   parameter logic [ADDR_W-1:0] BASE_ADDR   = 10'h300,
   parameter int                SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [1:0]        cs_ppi,
   output logic              cs_ctr,
   input  logic [2:0]        ext_in,
   input  logic              osc_tick,
   input  logic [2:0]        ctr_out,
   output logic [2:0]        cnt_en,
   input  logic [1:0]        ppi_c0,
   input  logic              ext_irq,
   output logic [2:0]        irq_oe
);
   if (BASE_ADDR[WIN_W-1:0] != '0) begin : g_chk_base
      $error("BASE_ADDR must be aligned to the 16-byte window");
   end
   if (SYNC_STAGES < 1) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 1");
   end
   if (DATA_W < IRQCFG_W || ADDR_W <= WIN_W) begin : g_chk_width
      $error("DATA_W or ADDR_W too small");
   end

   logic                wr_insel, wr_irq, rd_insel, rd_irq;
   logic [INSEL_W-1:0]  insel;
   logic [IRQCFG_W-1:0] irqcfg;

   cir_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
      .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
      .cs_ppi(cs_ppi), .cs_ctr(cs_ctr),
      .wr_insel(wr_insel), .wr_irq(wr_irq),
      .rd_insel(rd_insel), .rd_irq(rd_irq));

   cir_regs #(.DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_insel(wr_insel), .wr_irq(wr_irq),
      .rd_insel(rd_insel), .rd_irq(rd_irq),
      .wdata(bus_wdata), .insel(insel), .irqcfg(irqcfg), .rdata(bus_rdata));

   cir_clk_route #(.SYNC_STAGES(SYNC_STAGES)) u_route (
      .clk(clk), .rst_n(rst_n), .insel(insel), .ext_in(ext_in),
      .osc_tick(osc_tick), .ctr_out(ctr_out), .cnt_en(cnt_en));

   cir_irq_steer #(.SYNC_STAGES(SYNC_STAGES)) u_irq (
      .clk(clk), .rst_n(rst_n), .irqcfg(irqcfg), .ppi_c0(ppi_c0),
      .ext_irq(ext_irq), .ctr_out(ctr_out), .irq_oe(irq_oe));

   a_r1_single_target: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cs_ppi, cs_ctr, wr_insel | rd_insel, wr_irq | rd_irq}));
   a_r4_rdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_insel || rd_irq) |-> (bus_rdata == '0));
endmodule

// File: tb/sim_cir_top.sv
module sim_cir_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [9:0] bus_addr = '0;
   logic       bus_rd = 1'b0, bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [1:0] cs_ppi;
   logic       cs_ctr;
   logic [2:0] ext_in = '0;
   logic       osc_tick = 1'b0;
   logic [2:0] ctr_out = '0;
   logic [2:0] cnt_en;
   logic [1:0] ppi_c0 = '0;
   logic       ext_irq = 1'b0;
   logic [2:0] irq_oe;

   int n_chk = 0, n_bad = 0;
   int pulses [3];
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   cir_top u0 (.*);

   always @(negedge clk)
      for (int i = 0; i < 3; i++) if (cnt_en[i]) pulses[i]++;

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_write(logic [9:0] a, logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = '0;
   endtask

   task automatic bus_read(logic [9:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0; bus_addr = '0;
   endtask

   task automatic t_reset;
      logic [7:0] d;
      check("R2 reset insel", 0, 0);
      bus_read(10'h30C, d); check("R2 insel reset", d, 0);
      bus_read(10'h30E, d); check("R3 irqcfg reset", d, 0);
      check("R8 irq_oe reset", irq_oe, 0);
      check("R5 cnt_en reset", cnt_en, 0);
   endtask

   task automatic t_decode;
      @(negedge clk);
      bus_addr = 10'h302; bus_rd = 1'b1; #1;
      check("R1 cs at 0x302", {cs_ppi, cs_ctr}, 3'b010);
      bus_addr = 10'h307; #1;
      check("R1 cs at 0x307", {cs_ppi, cs_ctr}, 3'b100);
      bus_rd = 1'b0; bus_wr = 1'b1; bus_addr = 10'h308; bus_wdata = 8'hFF; #1;
      check("R1 cs at 0x308 write", {cs_ppi, cs_ctr}, 3'b001);
      bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = 10'h202; #1;
      check("R1 no cs outside window", {cs_ppi, cs_ctr}, 3'b000);
      bus_rd = 1'b0; bus_addr = 10'h301; #1;
      check("R1 no cs without strobe", {cs_ppi, cs_ctr}, 3'b000);
      @(negedge clk);
   endtask

   task automatic t_regs;
      logic [7:0] d;
      bus_write(10'h30D, 8'hF6);
      bus_read(10'h30C, d); check("R2 alias write 13 read 12", d, 8'h16);
      bus_write(10'h30E, 8'hE9);
      bus_read(10'h30F, d); check("R3 alias write 14 read 15", d, 8'h29);
      bus_write(10'h20C, 8'h03);
      bus_write(10'h20F, 8'h00);
      bus_write(10'h30B, 8'h00);
      bus_read(10'h30D, d); check("R4 insel unchanged", d, 8'h16);
      bus_read(10'h30E, d); check("R4 irqcfg unchanged", d, 8'h29);
      bus_read(10'h300, d); check("R4 rdata zero at offset 0", d, 0);
      bus_read(10'h20C, d); check("R4 rdata zero outside", d, 0);
      bus_write(10'h30C, 8'h00);
      bus_write(10'h30E, 8'h00);
   endtask

   // all sources in sequence: 3 pin edges, 5 osc ticks, 4 ctr0 edges, 6 ctr1 edges
   task automatic drive_sources;
      for (int i = 0; i < 3; i++) begin
         ext_in = 3'b111; cyc(3); ext_in = 3'b000; cyc(3);
      end
      for (int i = 0; i < 5; i++) begin
         osc_tick = 1'b1; cyc(1); osc_tick = 1'b0; cyc(3);
      end
      for (int i = 0; i < 4; i++) begin
         ctr_out[0] = 1'b1; cyc(2); ctr_out[0] = 1'b0; cyc(2);
      end
      for (int i = 0; i < 6; i++) begin
         ctr_out[1] = 1'b1; cyc(2); ctr_out[1] = 1'b0; cyc(2);
      end
      cyc(8);
   endtask

   task automatic t_route(logic [9:0] a, logic [4:0] sel, int e0, int e1, int e2, string tag);
      bus_write(a, {3'b000, sel});
      cyc(2);
      for (int i = 0; i < 3; i++) pulses[i] = 0;
      drive_sources();
      check({"R5 counter0 ", tag}, pulses[0], e0);
      check({"R6 counter1 ", tag}, pulses[1], e1);
      check({"R7 counter2 ", tag}, pulses[2], e2);
   endtask

   task automatic t_irq;
      bus_write(10'h30E, 8'h07);
      ppi_c0 = 2'b01; ext_irq = 1'b0; cyc(5);
      check("R8 port sources 01/0", irq_oe, 3'b001);
      ppi_c0 = 2'b10; ext_irq = 1'b1; cyc(5);
      check("R8 port sources 10/1", irq_oe, 3'b110);
      bus_write(10'h30F, 8'h3F);
      ppi_c0 = 2'b11; ext_irq = 1'b1; ctr_out = 3'b101; cyc(5);
      check("R8 counter sources", irq_oe, 3'b101);
      bus_write(10'h30E, 8'h38);
      ctr_out = 3'b111; cyc(5);
      check("R9 disabled stays low", irq_oe, 3'b000);
      bus_write(10'h30E, 8'h02);
      cyc(5);
      check("R9 only line 1 enabled", irq_oe, 3'b010);
      ctr_out = 3'b000; ppi_c0 = 2'b00; ext_irq = 1'b0;
      bus_write(10'h30E, 8'h00);
   endtask

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(2);
      t_reset();
      t_decode();
      t_regs();
      t_route(10'h30C, 5'b00_00_0, 3, 3, 3, "all pins");
      t_route(10'h30D, 5'b01_01_1, 5, 5, 5, "all osc");
      t_route(10'h30C, 5'b10_10_0, 3, 4, 6, "chained");
      t_route(10'h30D, 5'b11_11_1, 5, 4, 6, "chained 11");
      t_irq();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule